// File: doc/BRIEF.md
# Debug Vector Catch Controller

This block holds the debug exception and monitor control word of a processor core and turns selected exception events into debug actions. Software or a debug port reads and writes the word through a simple register port. Each bit in the catch field arms one class of fault or exception. When an armed event arrives, the block routes it one of three ways. If halting debug is on, it raises a halt request. If the debug monitor is enabled instead, it pends the monitor. If neither is active, it escalates the event to hard fault.

A halt is not taken at the moment of the event. The block first records a pending halt. It raises the halt request at the next instruction-boundary strobe, so the core stops on the first instruction of the handler. While that halt is pending during vectoring, the block suppresses late-arriving interrupts. If a vector-read or stack-push fault hits in that window, the halt is retargeted to the handler for that fault. The control word lives in the power-on reset domain, so a system reset leaves it untouched. A system reset clears only the request state.

Top module: `dbg_catch_ctrl`

## Requirements
- R1: Writes update the writable bits: bit 0 (core-reset catch), bits 4 to 10 (catch enables for event vector bits 0 to 6), bit 16 (monitor enable) and bit 17 (monitor pend). A read returns the stored value on `reg_rdata` in the cycle after the write.
- R2: Bits 1 to 3, 11 to 15 and 18 to 31 always read as zero. A write of ones to them leaves the read value at 0x000307F1.
- R3: Power-on reset (`por_n` low at a clock edge) clears the control word and all request state. System reset (`sys_rst_n` low) clears halt and escalation state but leaves the control word unchanged.
- R4: Conditions for a halt request:
  - With `halt_dbg_en` high, an event whose catch bit is set records a pending halt at the next edge.
  - `halt_req` rises at the edge that samples `instr_bnd` high while the halt is pending, and not before.
  - Events whose catch bit is clear are ignored.
- R5: `halt_req` stays high until `halt_ack` is sampled. That edge clears the request, the pending halt and `halt_cause` (0).
- R6: `halt_cause` names the caught event. The codes are: 1 core reset, 2 event bit 0 (memory management), 3 bit 1 (absent coprocessor), 4 bit 2 (checking error), 5 bit 3 (state error), 6 bit 4 (bus error), 7 bit 5 (interrupt-service error), 8 bit 6 (hard fault), 9 vectoring fault. Among simultaneous events, the order of precedence is core reset, then interrupt-service, bus, hard, state, checking, coprocessor and memory management. A later event does not change the cause of a halt already pending.
- R7: `vec_fault` sampled high while a halt is pending, not yet requested, and `vectoring` is high sets `halt_cause` to 9 at that edge.
- R8: `late_arr_sup` is high exactly while a halt is pending, `halt_req` is low and `vectoring` is high.
- R9: With `halt_dbg_en` low and monitor enable set, an armed event sets the monitor pend bit (bit 17) at the next edge. It raises no halt.
- R10: `mon_req` is high when all of the following hold:
  - the pend bit is set;
  - the monitor enable bit is set;
  - `halt_dbg_en` is low;
  - `mon_prio` is numerically lower (more urgent) than `cur_prio`.
- R11: `mon_entry` sampled high clears the pend bit. A write of 0 to bit 17 also clears it.
- R12: With `halt_dbg_en` low and monitor enable clear, an armed event makes `hardfault_esc` high for exactly the one cycle after the event edge. The pend bit and `halt_req` are left unchanged.
- R13: With bit 0 set and halting debug on, a `core_rst_evt` pulse produces a halt with cause 1 at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| sys_rst_n | input | 1 | System reset, synchronous, active low |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read value |
| evt_vec | input | 7 | One-cycle fault event pulses, one bit per class |
| core_rst_evt | input | 1 | Core reset event pulse |
| vectoring | input | 1 | Exception vectoring in progress |
| vec_fault | input | 1 | Vector-read or stack-push fault during vectoring |
| instr_bnd | input | 1 | Instruction boundary strobe |
| halt_dbg_en | input | 1 | Halting debug enabled |
| halt_ack | input | 1 | Core has entered halt |
| cur_prio | input | 8 | Current execution priority, lower is more urgent |
| mon_prio | input | 8 | Debug monitor priority, lower is more urgent |
| mon_entry | input | 1 | Monitor handler entered |
| halt_req | output | 1 | Halt request |
| halt_cause | output | 4 | Cause code of the pending or requested halt |
| mon_req | output | 1 | Debug monitor request |
| hardfault_esc | output | 1 | Escalate debug event to hard fault, one-cycle pulse |
| late_arr_sup | output | 1 | Suppress late-arriving interrupt preemption |

## Verification
Some internal faults show up at once. A pending halt that is lost or set by mistake appears as a wrong `late_arr_sup` in the same cycle, or as a missing or early `halt_req` at the first boundary strobe after the event. A wrong cause selection or a missed retarget appears on `halt_cause` one edge after the event or the fault. Other faults show up only later. A control word hit by the wrong reset domain, or a pend bit that fails to set or clear, appears on `reg_rdata` and `mon_req` in the cycle after the edge. A control word hit by a system reset shows only when a system reset has passed, so the bench reads the word back directly after one.

// File: rtl/dbg_catch_pkg.sv
// Package: shared field positions, masks and cause codes for the
// debug vector catch controller. Assumes a 32-bit control word.
package dbg_catch_pkg;
    localparam int REG_W      = 32;
    localparam int N_EVT      = 7;   // event classes in evt_vec
    localparam int CATCH_LSB  = 4;   // catch enable for evt_vec[i] is bit CATCH_LSB+i
    localparam int B_CORE     = 0;
    localparam int B_MON_EN   = 16;
    localparam int B_MON_PEND = 17;
    localparam int PRIO_W     = 8;

    // event vector indices
    localparam int EV_MM    = 0;
    localparam int EV_NOCP  = 1;
    localparam int EV_CHK   = 2;
    localparam int EV_STATE = 3;
    localparam int EV_BUS   = 4;
    localparam int EV_ISR   = 5;
    localparam int EV_HARD  = 6;

    localparam logic [REG_W-1:0] CATCH_FIELD = ((REG_W'(1) << N_EVT) - 1) << CATCH_LSB;
    localparam logic [REG_W-1:0] WR_MASK = CATCH_FIELD
                                         | (REG_W'(1) << B_CORE)
                                         | (REG_W'(1) << B_MON_EN)
                                         | (REG_W'(1) << B_MON_PEND);

    typedef enum logic [3:0] {
        CAUSE_NONE  = 4'd0,
        CAUSE_CORE  = 4'd1,
        CAUSE_MM    = 4'd2,
        CAUSE_NOCP  = 4'd3,
        CAUSE_CHK   = 4'd4,
        CAUSE_STATE = 4'd5,
        CAUSE_BUS   = 4'd6,
        CAUSE_ISR   = 4'd7,
        CAUSE_HARD  = 4'd8,
        CAUSE_VEC   = 4'd9
    } cause_e;
endpackage

// File: rtl/dbg_catch_regs.sv
// Control word storage in the power-on reset domain.
// Does: masks writes to the writable fields, lets hardware set or clear
// the monitor pend bit. Assumes: hardware set wins over a clear in the
// same cycle; system reset is deliberately not an input here.
module dbg_catch_regs
    import dbg_catch_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             pend_set,
    input  logic             pend_clr,
    output logic [REG_W-1:0] ctl
);
    logic [REG_W-1:0] ctl_nxt;

    // Next value: masked write, then hardware clear, then hardware set.
    always_comb begin
        ctl_nxt = wr_en ? (wdata & WR_MASK) : ctl;
        if (pend_clr) ctl_nxt[B_MON_PEND] = 1'b0;
        if (pend_set) ctl_nxt[B_MON_PEND] = 1'b1;
    end

    // Storage, cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n) ctl <= '0;
        else        ctl <= ctl_nxt;
    end

    // R9
    pend_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        pend_set |=> ctl[B_MON_PEND]);
    // R11
    pend_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
        (pend_clr && !pend_set) |=> !ctl[B_MON_PEND]);
endmodule

// File: rtl/dbg_catch_sel.sv
// Catch selector: masks event pulses with their catch enables and picks
// one cause by fixed precedence. Purely combinational.
// Assumes event inputs are single-cycle pulses.
module dbg_catch_sel
    import dbg_catch_pkg::*;
(
    input  logic [N_EVT-1:0] evt_vec,
    input  logic [N_EVT-1:0] catch_en,
    input  logic             core_evt,
    input  logic             core_en,
    output logic             any_hit,
    output cause_e           cause
);
    logic [N_EVT-1:0] hit_vec;
    logic             core_hit;

    genvar gi;
    generate
        for (gi = 0; gi < N_EVT; gi++) begin : g_mask
            assign hit_vec[gi] = evt_vec[gi] & catch_en[gi];
        end
    endgenerate

    assign core_hit = core_evt & core_en;
    assign any_hit  = core_hit | (|hit_vec);

    // Precedence: core reset, service error, bus, hard, state, check, coproc, mem.
    always_comb begin
        if      (core_hit)           cause = CAUSE_CORE;
        else if (hit_vec[EV_ISR])    cause = CAUSE_ISR;
        else if (hit_vec[EV_BUS])    cause = CAUSE_BUS;
        else if (hit_vec[EV_HARD])   cause = CAUSE_HARD;
        else if (hit_vec[EV_STATE])  cause = CAUSE_STATE;
        else if (hit_vec[EV_CHK])    cause = CAUSE_CHK;
        else if (hit_vec[EV_NOCP])   cause = CAUSE_NOCP;
        else if (hit_vec[EV_MM])     cause = CAUSE_MM;
        else                         cause = CAUSE_NONE;
    end
endmodule

// File: rtl/dbg_catch_halt.sv
// Halt sequencer: records a caught event as a pending halt, raises the
// request on the next instruction boundary, retargets on a vectoring
// fault, and flags late-arrival suppression while pending.
// Assumes halt_ack arrives only after halt_req.
module dbg_catch_halt
    import dbg_catch_pkg::*;
(
    input  logic   clk,
    input  logic   por_n,
    input  logic   sys_rst_n,
    input  logic   hit,
    input  cause_e hit_cause,
    input  logic   halt_mode,
    input  logic   instr_bnd,
    input  logic   vectoring,
    input  logic   vec_fault,
    input  logic   halt_ack,
    output logic   halt_req,
    output cause_e halt_cause,
    output logic   late_sup
);
    logic pend;
    logic rst_any;

    assign rst_any = !por_n || !sys_rst_n;

    // Pending halt, request and cause state.
    always_ff @(posedge clk) begin
        if (rst_any || halt_ack) begin
            pend       <= 1'b0;
            halt_req   <= 1'b0;
            halt_cause <= CAUSE_NONE;
        end else begin
            if (!pend && hit && halt_mode) begin
                pend       <= 1'b1;
                halt_cause <= hit_cause;
            end else if (pend && !halt_req && vectoring && vec_fault) begin
                halt_cause <= CAUSE_VEC;
            end
            if (pend && instr_bnd) halt_req <= 1'b1;
        end
    end

    // Suppress late arrival while a caught halt waits during vectoring.
    assign late_sup = pend && !halt_req && vectoring;

    // R4
    halt_bnd_chk: assert property (@(posedge clk) disable iff (rst_any)
        $rose(halt_req) |-> $past(instr_bnd));
    // R5
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst_any)
        (halt_req && !halt_ack) |=> halt_req);
    // R5
    halt_ack_chk: assert property (@(posedge clk) disable iff (rst_any)
        halt_ack |=> !halt_req);
    // R7
    retarget_chk: assert property (@(posedge clk) disable iff (rst_any)
        (pend && !halt_req && vectoring && vec_fault && !halt_ack) |=> (halt_cause == CAUSE_VEC));
endmodule

// File: rtl/dbg_catch_ctrl.sv
// Top: debug vector catch controller. Routes caught events to halt,
// monitor pend or hard-fault escalation, and gates the monitor request
// by priority. Assumes lower priority values are more urgent.
module dbg_catch_ctrl
    import dbg_catch_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [N_EVT-1:0]  evt_vec,
    input  logic              core_rst_evt,
    input  logic              vectoring,
    input  logic              vec_fault,
    input  logic              instr_bnd,
    input  logic              halt_dbg_en,
    input  logic              halt_ack,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [PRIO_W-1:0] mon_prio,
    input  logic              mon_entry,
    output logic              halt_req,
    output logic [3:0]        halt_cause,
    output logic              mon_req,
    output logic              hardfault_esc,
    output logic              late_arr_sup
);
    logic [REG_W-1:0] ctl;
    logic             any_hit;
    cause_e           sel_cause;
    cause_e           cause_q;
    logic             mon_set;
    logic             mon_en;

    assign mon_en  = ctl[B_MON_EN];
    assign mon_set = any_hit && !halt_dbg_en && mon_en;

    dbg_catch_regs u_regs (
        .clk      (clk),
        .por_n    (por_n),
        .wr_en    (reg_wr_en),
        .wdata    (reg_wdata),
        .pend_set (mon_set),
        .pend_clr (mon_entry),
        .ctl      (ctl)
    );

    dbg_catch_sel u_sel (
        .evt_vec  (evt_vec),
        .catch_en (ctl[CATCH_LSB +: N_EVT]),
        .core_evt (core_rst_evt),
        .core_en  (ctl[B_CORE]),
        .any_hit  (any_hit),
        .cause    (sel_cause)
    );

    dbg_catch_halt u_halt (
        .clk        (clk),
        .por_n      (por_n),
        .sys_rst_n  (sys_rst_n),
        .hit        (any_hit),
        .hit_cause  (sel_cause),
        .halt_mode  (halt_dbg_en),
        .instr_bnd  (instr_bnd),
        .vectoring  (vectoring),
        .vec_fault  (vec_fault),
        .halt_ack   (halt_ack),
        .halt_req   (halt_req),
        .halt_cause (cause_q),
        .late_sup   (late_arr_sup)
    );

    assign halt_cause = cause_q;
    assign reg_rdata  = ctl;

    // Monitor request: pend, enabled, not overridden, priority permits.
    assign mon_req = ctl[B_MON_PEND] && mon_en && !halt_dbg_en && (mon_prio < cur_prio);

    // One-cycle escalation when neither debug path is available.
    always_ff @(posedge clk) begin
        if (!por_n || !sys_rst_n) hardfault_esc <= 1'b0;
        else                      hardfault_esc <= any_hit && !halt_dbg_en && !mon_en;
    end

    // R3
    sysrst_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst_n && !reg_wr_en && !mon_entry && !any_hit) |=> $stable(reg_rdata));
    // R12
    esc_mode_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        hardfault_esc |-> !$past(halt_dbg_en));
    // R12
    esc_pulse_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (hardfault_esc && !any_hit) |=> !hardfault_esc);
endmodule

// File: tb/dbg_catch_ctrl_tb.sv
// Directed bench for dbg_catch_ctrl: one task per scenario.
module dbg_catch_ctrl_tb;
    logic        clk = 1'b0;
    logic        por_n, sys_rst_n, reg_wr_en;
    logic [31:0] reg_wdata, reg_rdata;
    logic [6:0]  evt_vec;
    logic        core_rst_evt, vectoring, vec_fault, instr_bnd;
    logic        halt_dbg_en, halt_ack, mon_entry;
    logic [7:0]  cur_prio, mon_prio;
    logic        halt_req, mon_req, hardfault_esc, late_arr_sup;
    logic [3:0]  halt_cause;
    int          n_chk = 0;
    int          n_err = 0;

    always #2 clk = ~clk;

    dbg_catch_ctrl u_dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_vec(evt_vec), .core_rst_evt(core_rst_evt), .vectoring(vectoring),
        .vec_fault(vec_fault), .instr_bnd(instr_bnd), .halt_dbg_en(halt_dbg_en),
        .halt_ack(halt_ack), .cur_prio(cur_prio), .mon_prio(mon_prio),
        .mon_entry(mon_entry), .halt_req(halt_req), .halt_cause(halt_cause),
        .mon_req(mon_req), .hardfault_esc(hardfault_esc), .late_arr_sup(late_arr_sup)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wdata = d; step(); reg_wr_en = 1'b0;
    endtask

    task automatic pulse_evt(input logic [6:0] e, input logic core);
        evt_vec = e; core_rst_evt = core; step(); evt_vec = '0; core_rst_evt = 1'b0;
    endtask

    task automatic bnd();
        instr_bnd = 1'b1; step(); instr_bnd = 1'b0;
    endtask

    task automatic ack();
        halt_ack = 1'b1; step(); halt_ack = 1'b0;
    endtask

    task automatic do_por();
        por_n = 1'b0; step(); step(); por_n = 1'b1;
    endtask

    task automatic t_reset();
        chk("R3 por rdata", reg_rdata, 32'h0);
        chk("R3 por halt_req", {31'b0, halt_req}, 32'h0);
        chk("R3 por mon_req", {31'b0, mon_req}, 32'h0);
        chk("R3 por esc", {31'b0, hardfault_esc}, 32'h0);
        chk("R3 por sup", {31'b0, late_arr_sup}, 32'h0);
    endtask

    task automatic t_regs();
        wr(32'hFFFF_FFFF);
        chk("R2 reserved read zero", reg_rdata, 32'h0003_07F1);
        wr(32'h0001_0511);
        chk("R1 readback", reg_rdata, 32'h0001_0511);
        wr(32'h0);
        chk("R1 clear", reg_rdata, 32'h0);
    endtask

    task automatic t_halt();
        wr(32'h0000_0100);
        halt_dbg_en = 1'b1;
        pulse_evt(7'h01, 1'b0);
        bnd();
        chk("R4 disabled catch ignored", {31'b0, halt_req}, 32'h0);
        pulse_evt(7'h10, 1'b0);
        step(); step();
        chk("R4 no halt before boundary", {31'b0, halt_req}, 32'h0);
        bnd();
        chk("R4 halt at boundary", {31'b0, halt_req}, 32'h1);
        chk("R6 bus cause", {28'b0, halt_cause}, 32'd6);
        step(); step(); step();
        chk("R5 halt held", {31'b0, halt_req}, 32'h1);
        ack();
        chk("R5 ack clears req", {31'b0, halt_req}, 32'h0);
        chk("R5 ack clears cause", {28'b0, halt_cause}, 32'h0);
    endtask

    task automatic one_prio(input logic [6:0] e, input logic core, input logic [3:0] exp, input string tag);
        pulse_evt(e, core);
        bnd();
        chk(tag, {28'b0, halt_cause}, {28'b0, exp});
        ack();
    endtask

    task automatic t_prio();
        wr(32'h0000_07F1);
        halt_dbg_en = 1'b1;
        one_prio(7'h70, 1'b0, 4'd7, "R6 service error first");
        one_prio(7'h50, 1'b0, 4'd6, "R6 bus before hard");
        one_prio(7'h48, 1'b0, 4'd8, "R6 hard before state");
        one_prio(7'h03, 1'b0, 4'd3, "R6 coproc before mem");
        one_prio(7'h20, 1'b1, 4'd1, "R13 core reset catch");
        pulse_evt(7'h10, 1'b0);
        pulse_evt(7'h20, 1'b0);
        bnd();
        chk("R6 later event keeps cause", {28'b0, halt_cause}, 32'd6);
        ack();
    endtask

    task automatic t_retarget();
        wr(32'h0000_0100);
        halt_dbg_en = 1'b1;
        pulse_evt(7'h10, 1'b0);
        chk("R8 no sup without vectoring", {31'b0, late_arr_sup}, 32'h0);
        vectoring = 1'b1; #1;
        chk("R8 sup while pending", {31'b0, late_arr_sup}, 32'h1);
        vec_fault = 1'b1; step(); vec_fault = 1'b0;
        chk("R7 retarget cause", {28'b0, halt_cause}, 32'd9);
        bnd();
        chk("R7 halt after retarget", {31'b0, halt_req}, 32'h1);
        chk("R8 sup off after req", {31'b0, late_arr_sup}, 32'h0);
        vectoring = 1'b0;
        ack();
    endtask

    task automatic t_mon();
        halt_dbg_en = 1'b0;
        wr(32'h0001_0100);
        mon_prio = 8'd3; cur_prio = 8'd2;
        pulse_evt(7'h10, 1'b0);
        chk("R9 pend set by catch", reg_rdata, 32'h0003_0100);
        bnd();
        chk("R9 no halt in monitor mode", {31'b0, halt_req}, 32'h0);
        chk("R10 blocked by priority", {31'b0, mon_req}, 32'h0);
        cur_prio = 8'd5; #1;
        chk("R10 request when urgent", {31'b0, mon_req}, 32'h1);
        halt_dbg_en = 1'b1; #1;
        chk("R10 halting overrides", {31'b0, mon_req}, 32'h0);
        halt_dbg_en = 1'b0;
        mon_entry = 1'b1; step(); mon_entry = 1'b0;
        chk("R11 entry clears pend", reg_rdata, 32'h0001_0100);
        chk("R11 entry drops req", {31'b0, mon_req}, 32'h0);
        wr(32'h0003_0100);
        chk("R10 written pend requests", {31'b0, mon_req}, 32'h1);
        wr(32'h0001_0100);
        chk("R11 write clears pend", {31'b0, mon_req}, 32'h0);
        wr(32'h0002_0000);
        chk("R10 pend without enable", {31'b0, mon_req}, 32'h0);
    endtask

    task automatic t_esc();
        halt_dbg_en = 1'b0;
        wr(32'h0000_0400);
        pulse_evt(7'h40, 1'b0);
        chk("R12 escalate pulse", {31'b0, hardfault_esc}, 32'h1);
        step();
        chk("R12 pulse one cycle", {31'b0, hardfault_esc}, 32'h0);
        chk("R12 no pend", reg_rdata, 32'h0000_0400);
        bnd();
        chk("R12 no halt", {31'b0, halt_req}, 32'h0);
        pulse_evt(7'h10, 1'b0);
        chk("R12 disabled catch no esc", {31'b0, hardfault_esc}, 32'h0);
    endtask

    task automatic t_sysrst();
        wr(32'h0003_0510);
        halt_dbg_en = 1'b1;
        pulse_evt(7'h10, 1'b0);
        chk("R3 pending cause before reset", {28'b0, halt_cause}, 32'd6);
        sys_rst_n = 1'b0; step(); step(); sys_rst_n = 1'b1;
        chk("R3 sys reset keeps word", reg_rdata, 32'h0003_0510);
        chk("R3 sys reset clears cause", {28'b0, halt_cause}, 32'h0);
        bnd();
        chk("R3 sys reset clears pending", {31'b0, halt_req}, 32'h0);
        do_por();
        chk("R3 por clears word", reg_rdata, 32'h0);
    endtask

    initial begin
        por_n = 1'b0; sys_rst_n = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0;
        evt_vec = '0; core_rst_evt = 1'b0; vectoring = 1'b0; vec_fault = 1'b0;
        instr_bnd = 1'b0; halt_dbg_en = 1'b0; halt_ack = 1'b0; mon_entry = 1'b0;
        cur_prio = 8'd4; mon_prio = 8'd4;
        @(negedge clk); step(); step();
        por_n = 1'b1; sys_rst_n = 1'b1;
        t_reset();
        t_regs();
        t_halt();
        t_prio();
        t_retarget();
        t_mon();
        t_esc();
        t_sysrst();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule